// File: doc/BRIEF.md
# SCSI Controller Register Front-End

This block is the host-visible register file of a small SCSI protocol controller. A byte-wide register port reaches 64 register offsets. The offset comes from the word-aligned address bits [7:2]. Host writes always land in a write bank. Reads come from a separate read bank, which holds the status, interrupt and sequence-step codes, the last byte taken from the FIFO, and a fixed identification value. A 32-byte transfer FIFO sits behind offset 2. An internal data-phase engine fills it one byte per strobe, and the host drains it by reading.

The controller core around this block signals two kinds of event with single-cycle strobes. A selection request carries the target number held in write register 4; if that target is absent, the block loads the fixed disconnect codes. A status-phase completion loads the fixed completion codes and puts a two-byte status reply into the FIFO. The block has one level interrupt request. Several events set it, and only a read of the interrupt register clears it.

Top module: `scsi_fe_regs`

## Requirements
- R1: After reset, every offset reads 0x00 except offset 0x0E, which reads 0x04, and `irq_o` is low.
- R2: The register offset is `bus_addr[7:2]`. Address bits [1:0] are ignored, so 0x38 and 0x3B both reach offset 0x0E.
- R3: The FIFO holds DEPTH (32) bytes. Each `eng_push` appends `eng_data` in arrival order, and a push into a full FIFO is dropped. Offset 7 reads the number of bytes held.
- R4: Reading offset 2 while the FIFO holds data returns the oldest byte, removes it, and raises `irq_o`. When the count reaches zero, both FIFO pointers return to entry 0.
- R5: Reading offset 2 while the FIFO is empty returns the last byte removed (0x00 after reset). The count and `irq_o` are unchanged.
- R6: Reading offset 5 returns the interrupt code and then clears it to 0x00. The same read clears status bits 7, 6 and 5 (mask 0xE0), keeps status bits 4..0, and drops `irq_o` unless another event raises it in that cycle.
- R7: Writing offset 3 with bits [6:0] = 0x03 is a bus-reset command (bit 7 is ignored). It loads interrupt code 0x80. It raises `irq_o` only when bit 6 of write register 8 is clear.
- R8: On `sel_req`, the target is write register 4 bits [2:0], and `sel_target` shows it. If `tgt_present` has that bit clear, status becomes 0x80, interrupt becomes 0x20, sequence step (offset 6) becomes 0x00, and `irq_o` rises. If the target is present, nothing changes.
- R9: On `stat_done`, the FIFO is replaced by the two bytes `stat_code` then 0x00, offset 7 reads 2, status becomes 0x93, interrupt becomes 0x18, sequence step becomes 0x04, and `irq_o` rises.
- R10: A host write never changes a read-bank value. Writing 0xFF to offsets 2, 4, 5, 6, 7 and 0x0E leaves what those offsets read unchanged.
- R11: Once raised, `irq_o` stays high until an offset-5 read or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe; side effects at the clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address; offset is bits [7:2] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| eng_push | input | 1 | Data-phase engine FIFO load strobe |
| eng_data | input | 8 | Byte to load into the FIFO |
| sel_req | input | 1 | Selection attempt strobe |
| tgt_present | input | NTGT | One bit per target; 1 means present |
| stat_done | input | 1 | Status-phase completion strobe |
| stat_code | input | 8 | Status byte for the status reply |
| sel_target | output | $clog2(NTGT) | Target number from write register 4 |
| irq_o | output | 1 | Interrupt request, level |

## Verification
Checked on every cycle inside the RTL:
- the FIFO count never exceeds its depth, and a push into a full FIFO leaves the count unchanged;
- the last pop sends both pointers home;
- a pop always leaves the interrupt request high;
- a masked bus reset never raises the request;
- a completion or target-missing event always leaves the fixed codes and a raised request in the following cycle.

The bench scenarios show what the properties cannot:
- bytes leave the FIFO in arrival order, including after the pointers wrap;
- an empty read returns the last byte;
- read-to-clear drops exactly the status bits in 0xE0;
- host writes to read-back offsets change nothing visible.

// File: rtl/scsi_fe_pkg.sv
package scsi_fe_pkg;
   localparam int OFF_W = 6;
   localparam int NREG  = 1 << OFF_W;

   typedef logic [7:0]       byte_t;
   typedef logic [OFF_W-1:0] off_t;

   localparam off_t OFF_FIFO  = 6'h02;
   localparam off_t OFF_CMD   = 6'h03;
   localparam off_t OFF_STAT  = 6'h04;
   localparam off_t OFF_INTR  = 6'h05;
   localparam off_t OFF_SEQ   = 6'h06;
   localparam off_t OFF_FLAGS = 6'h07;
   localparam off_t OFF_CFG   = 6'h08;
   localparam off_t OFF_ID    = 6'h0E;

   localparam byte_t ID_VALUE     = 8'h04;
   localparam byte_t CMD_BUSRST   = 8'h03;
   localparam byte_t ST_CLR_MASK  = 8'hE0;
   localparam byte_t ST_MISSING   = 8'h80;
   localparam byte_t ST_DONE      = 8'h93;
   localparam byte_t INT_BUSRST   = 8'h80;
   localparam byte_t INT_DISC     = 8'h20;
   localparam byte_t INT_DONE     = 8'h18;
   localparam byte_t SEQ_MISSING  = 8'h00;
   localparam byte_t SEQ_DONE     = 8'h04;
   localparam int    CFG_MASK_BIT = 6;
endpackage

// File: rtl/scsi_fe_wbank.sv
module scsi_fe_wbank
   import scsi_fe_pkg::*;
#(
   parameter int N = NREG
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [$clog2(N)-1:0] waddr,
   input  byte_t                wdata,
   output logic [N-1:0][7:0]    regs
);
   for (genvar i = 0; i < N; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (we && waddr == i[$clog2(N)-1:0])
            regs[i] <= wdata;
      end
   end
endmodule

// File: rtl/scsi_fe_fifo.sv
module scsi_fe_fifo
   import scsi_fe_pkg::*;
#(
   parameter int DEPTH = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  byte_t                      push_data,
   input  logic                       pop,
   input  logic                       load_pair,
   input  byte_t                      pair_first,
   output byte_t                      head,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH > 255) begin : g_bad_depth
      $error("scsi_fe_fifo: DEPTH must be a power of two in 4..128");
   end

   byte_t            mem [DEPTH];
   logic [PTR_W-1:0] rptr, wptr;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic             do_push, do_pop;

   assign do_push = push && (cnt != CNT_W'(DEPTH));
   assign do_pop  = pop && (cnt != '0);
   assign cnt_nxt = cnt + CNT_W'(do_push) - CNT_W'(do_pop);
   assign head    = mem[rptr];
   assign count   = cnt;

   always_ff @(posedge clk) begin
      if (load_pair) begin
         mem[0] <= pair_first;
         mem[1] <= '0;
      end else if (do_push) begin
         mem[wptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr <= '0;
         wptr <= '0;
         cnt  <= '0;
      end else if (load_pair) begin
         rptr <= '0;
         wptr <= PTR_W'(2);
         cnt  <= CNT_W'(2);
      end else begin
         cnt <= cnt_nxt;
         if (cnt_nxt == '0) begin
            rptr <= '0;
            wptr <= '0;
         end else begin
            rptr <= rptr + PTR_W'(do_pop);
            wptr <= wptr + PTR_W'(do_push);
         end
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push && cnt == CNT_W'(DEPTH) && !pop && !load_pair |=> $stable(cnt));
   assert_ptr_home_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop && cnt == CNT_W'(1) && !push && !load_pair |=> (rptr == '0 && wptr == '0));
endmodule

// File: rtl/scsi_fe_regs.sv
module scsi_fe_regs
   import scsi_fe_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int NTGT  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_rd,
   input  logic                    bus_wr,
   input  logic [7:0]              bus_addr,
   input  logic [7:0]              bus_wdata,
   output logic [7:0]              bus_rdata,
   input  logic                    eng_push,
   input  logic [7:0]              eng_data,
   input  logic                    sel_req,
   input  logic [NTGT-1:0]         tgt_present,
   input  logic                    stat_done,
   input  logic [7:0]              stat_code,
   output logic [$clog2(NTGT)-1:0] sel_target,
   output logic                    irq_o
);
   localparam int TGT_W = $clog2(NTGT);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (NTGT < 2 || NTGT > 8 || (NTGT & (NTGT - 1)) != 0) begin : g_bad_ntgt
      $error("scsi_fe_regs: NTGT must be 2, 4 or 8");
   end

   off_t                off;
   logic [NREG-1:0][7:0] wregs;
   byte_t               fifo_head, stat_q, intr_q, seq_q, last_q;
   logic [CNT_W-1:0]    fifo_cnt;
   logic                rd_fifo, pop, rd_intr, busrst, rst_mask, sel_miss, raise;

   assign off        = bus_addr[7:2];
   assign sel_target = wregs[OFF_STAT][TGT_W-1:0];
   assign rd_fifo    = bus_rd && off == OFF_FIFO;
   assign pop        = rd_fifo && fifo_cnt != '0;
   assign rd_intr    = bus_rd && off == OFF_INTR;
   assign busrst     = bus_wr && off == OFF_CMD && bus_wdata[6:0] == CMD_BUSRST[6:0];
   assign rst_mask   = wregs[OFF_CFG][CFG_MASK_BIT];
   assign sel_miss   = sel_req && !tgt_present[sel_target];
   assign raise      = pop || (busrst && !rst_mask) || sel_miss || stat_done;

   scsi_fe_wbank #(.N(NREG)) u_wbank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr),
      .waddr (off),
      .wdata (bus_wdata),
      .regs  (wregs)
   );

   scsi_fe_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (eng_push),
      .push_data  (eng_data),
      .pop        (pop),
      .load_pair  (stat_done),
      .pair_first (stat_code),
      .head       (fifo_head),
      .count      (fifo_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         intr_q <= '0;
         seq_q  <= '0;
         last_q <= '0;
         irq_o  <= 1'b0;
      end else begin
         if (rd_intr) begin
            stat_q <= stat_q & ~ST_CLR_MASK;
            intr_q <= '0;
         end
         if (pop) last_q <= fifo_head;
         if (busrst) intr_q <= INT_BUSRST;
         if (sel_miss) begin
            stat_q <= ST_MISSING;
            intr_q <= INT_DISC;
            seq_q  <= SEQ_MISSING;
         end
         if (stat_done) begin
            stat_q <= ST_DONE;
            intr_q <= INT_DONE;
            seq_q  <= SEQ_DONE;
         end
         irq_o <= raise || (irq_o && !rd_intr);
      end
   end

   always_comb begin
      unique case (off)
         OFF_FIFO:  bus_rdata = (fifo_cnt != '0) ? fifo_head : last_q;
         OFF_STAT:  bus_rdata = stat_q;
         OFF_INTR:  bus_rdata = intr_q;
         OFF_SEQ:   bus_rdata = seq_q;
         OFF_FLAGS: bus_rdata = 8'(fifo_cnt);
         OFF_ID:    bus_rdata = ID_VALUE;
         default:   bus_rdata = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{wregs, bus_addr[1:0]};

   assert_pop_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fifo && fifo_cnt != '0 |=> irq_o);
   assert_masked_busrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busrst && rst_mask && !irq_o && !bus_rd && !sel_req && !stat_done |=> !irq_o);
   assert_sel_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_miss && !stat_done |=> (intr_q == INT_DISC && irq_o));
   assert_stat_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_done |=> (fifo_cnt == CNT_W'(2) && stat_q == ST_DONE && irq_o));
   assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !rd_intr |=> irq_o);
endmodule

// File: tb/scsi_fe_regs_bench.sv
module scsi_fe_regs_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rd = 0, bus_wr = 0, eng_push = 0, sel_req = 0, stat_done = 0;
   logic [7:0] bus_addr = 0, bus_wdata = 0, eng_data = 0, stat_code = 0;
   logic [7:0] tgt_present = 8'hFF;
   logic [7:0] bus_rdata;
   logic [2:0] sel_target;
   logic       irq_o;
   int         tests = 0, fails = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   scsi_fe_regs u_scsi_fe_regs (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_push(eng_push), .eng_data(eng_data), .sel_req(sel_req),
      .tgt_present(tgt_present), .stat_done(stat_done), .stat_code(stat_code),
      .sel_target(sel_target), .irq_o(irq_o)
   );

   // behavioural reference model
   logic [7:0] mq[$];
   logic [7:0] m_w[64];
   logic [7:0] m_stat, m_intr, m_seq, m_last;
   bit         m_irq;
   int         m_off;
   bit         m_raise, m_clr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mq.delete();
         foreach (m_w[i]) m_w[i] = 8'h00;
         m_stat = 0; m_intr = 0; m_seq = 0; m_last = 0; m_irq = 0;
      end else begin
         m_off = int'(bus_addr) / 4;
         m_raise = 0; m_clr = 0;
         if (bus_rd && m_off == 5) begin m_stat = m_stat & 8'h1F; m_intr = 0; m_clr = 1; end
         if (bus_rd && m_off == 2 && mq.size() > 0) begin m_last = mq.pop_front(); m_raise = 1; end
         if (bus_wr && m_off == 3 && bus_wdata[6:0] == 7'h03) begin
            m_intr = 8'h80;
            if (!m_w[8][6]) m_raise = 1;
         end
         if (eng_push && mq.size() < 32) mq.push_back(eng_data);
         if (sel_req && !tgt_present[m_w[4][2:0]]) begin
            m_stat = 8'h80; m_intr = 8'h20; m_seq = 8'h00; m_raise = 1;
         end
         if (stat_done) begin
            mq.delete(); mq.push_back(stat_code); mq.push_back(8'h00);
            m_stat = 8'h93; m_intr = 8'h18; m_seq = 8'h04; m_raise = 1;
         end
         if (bus_wr) m_w[m_off] = bus_wdata;
         m_irq = m_raise || (m_irq && !m_clr);
      end
   end

   function automatic logic [7:0] m_read(input int off);
      case (off)
         2:  return (mq.size() > 0) ? mq[0] : m_last;
         4:  return m_stat;
         5:  return m_intr;
         6:  return m_seq;
         7:  return 8'(mq.size());
         14: return 8'h04;
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // per-cycle comparison of the interrupt line and target output (R11, R8)
   always @(negedge clk) begin
      if (rst_n) begin
         check("R11 irq vs model", int'(irq_o), int'(m_irq));
         check("R8 sel_target vs model", int'(sel_target), int'(m_w[4][2:0]));
      end
   end

   task automatic rd(input logic [7:0] addr, input string req, input int exp);
      @(negedge clk);
      bus_addr = addr; bus_rd = 1;
      #1;
      check(req, int'(bus_rdata), int'(m_read(int'(addr) / 4)));
      if (exp >= 0) check(req, int'(bus_rdata), exp);
      @(posedge clk); #1 bus_rd = 0;
   endtask

   task automatic wr(input logic [7:0] addr, input logic [7:0] d);
      @(negedge clk);
      bus_addr = addr; bus_wdata = d; bus_wr = 1;
      @(posedge clk); #1 bus_wr = 0;
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      eng_data = d; eng_push = 1;
      @(posedge clk); #1 eng_push = 0;
   endtask

   task automatic sel();
      @(negedge clk); sel_req = 1;
      @(posedge clk); #1 sel_req = 0;
   endtask

   task automatic status(input logic [7:0] s);
      @(negedge clk); stat_code = s; stat_done = 1;
      @(posedge clk); #1 stat_done = 0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      @(negedge clk);
      check("R1 irq after reset", int'(irq_o), 0);
      for (int i = 0; i < 64; i++) rd(8'(i * 4), "R1 reset value", (i == 14) ? 4 : 0);
      // R2: address low bits ignored
      rd(8'h3B, "R2 offset from addr[7:2]", 4);
      rd(8'h16, "R2 alias of offset 5", 0);
      // R10: host writes leave the read bank alone
      wr(8'h08, 8'hFF); wr(8'h10, 8'hFF); wr(8'h14, 8'hFF);
      wr(8'h18, 8'hFF); wr(8'h1C, 8'hFF); wr(8'h38, 8'hFF);
      rd(8'h08, "R10 fifo offset", 0);
      rd(8'h10, "R10 status", 0);
      rd(8'h14, "R10 interrupt", 0);
      rd(8'h18, "R10 sequence", 0);
      rd(8'h1C, "R10 flags", 0);
      rd(8'h38, "R10 id", 4);
      // R3: fill, count and overflow
      for (int i = 0; i < 5; i++) push(8'(8'h10 + i));
      rd(8'h1C, "R3 count 5", 5);
      for (int i = 5; i < 40; i++) push(8'(8'h10 + i));
      rd(8'h1C, "R3 count saturates at 32", 32);
      // R4: drain in order
      for (int i = 0; i < 32; i++) rd(8'h08, "R4 pop order", 8'h10 + i);
      @(negedge clk);
      check("R4 irq after pop", int'(irq_o), 1);
      // R5: empty read returns last byte
      rd(8'h08, "R5 empty read", 8'h2F);
      rd(8'h1C, "R5 count still 0", 0);
      // R6 / R11: interrupt clear
      rd(8'h14, "R6 interrupt code", 0);
      @(negedge clk);
      check("R6 irq cleared", int'(irq_o), 0);
      rd(8'h08, "R5 empty read no irq", 8'h2F);
      @(negedge clk);
      check("R5 irq unchanged", int'(irq_o), 0);
      // R4: pointer return and wrap
      for (int i = 0; i < 20; i++) push(8'(8'h40 + i));
      for (int i = 0; i < 20; i++) rd(8'h08, "R4 partial drain", 8'h40 + i);
      for (int i = 0; i < 30; i++) push(8'(8'h80 + i));
      for (int i = 0; i < 30; i++) rd(8'h08, "R4 after pointer reset", 8'h80 + i);
      rd(8'h14, "R6 clear", 0);
      // R7: bus reset command
      wr(8'h0C, 8'h03);
      @(negedge clk);
      check("R7 irq on bus reset", int'(irq_o), 1);
      rd(8'h14, "R7 interrupt code", 8'h80);
      rd(8'h14, "R6 cleared on read", 0);
      wr(8'h20, 8'h40);
      wr(8'h0C, 8'h83);
      @(negedge clk);
      check("R7 masked bus reset", int'(irq_o), 0);
      rd(8'h14, "R7 code loaded while masked", 8'h80);
      wr(8'h20, 8'h00);
      // R9: status phase
      status(8'h5A);
      @(negedge clk);
      check("R9 irq", int'(irq_o), 1);
      rd(8'h1C, "R9 flags 2", 2);
      rd(8'h10, "R9 status", 8'h93);
      rd(8'h18, "R9 sequence", 8'h04);
      rd(8'h08, "R9 status byte", 8'h5A);
      rd(8'h08, "R9 second byte", 8'h00);
      rd(8'h14, "R9 interrupt", 8'h18);
      rd(8'h10, "R6 status bits cleared", 8'h13);
      // R8: target missing and target present
      tgt_present = 8'b1111_0111;
      wr(8'h10, 8'h0B);
      @(negedge clk);
      check("R8 sel_target", int'(sel_target), 3);
      sel();
      @(negedge clk);
      check("R8 irq on missing target", int'(irq_o), 1);
      rd(8'h10, "R8 status", 8'h80);
      rd(8'h18, "R8 sequence", 8'h00);
      rd(8'h14, "R8 interrupt", 8'h20);
      wr(8'h10, 8'h02);
      sel();
      @(negedge clk);
      check("R8 present target no irq", int'(irq_o), 0);
      rd(8'h10, "R8 present status unchanged", 8'h00);
      rd(8'h14, "R8 present interrupt unchanged", 8'h00);
      repeat (3) @(negedge clk);
      done = 1;
      summary();
      $finish;
   end
endmodule